// File: doc/BRIEF.md
# Weighted Bin Random Value Generator

This block hands out pseudo-random values whose distribution is shaped by a small table of bins. Each bin holds a pair of bounds, and a count register says how many bins take part. Every accepted request runs two bounded draws one after the other. The first draw picks a bin uniformly among the counted bins. The second draw picks a value uniformly inside that bin's bounds. Writing the same bounds into several bins gives that range a larger share of the results. For example, four bins {0,0}, {1,10}, {11,100}, {11,100} give 0 a quarter of the time, 1..10 a quarter of the time, and 11..100 half of the time.

Both draws use one operation: scale a 16-bit random word by the size of the range with a shift-and-add multiplier, then keep the upper half of the product. No divider is needed, and the range need not be a power of two. Two independent 16-bit LFSRs supply the words, one for each draw. When a request is accepted, the table is copied into a working snapshot. Bus writes made after that point only affect later requests.

Top module: `binRandGen`

## Requirements
- R1: After reset, busy, respValid and respValue are all 0, the count register and all bounds are 0, and each LFSR holds its seed.
- R2: A write with wrEn high goes to bin k lower bound at wrAddr k (0..7), to bin k upper bound at wrAddr 8+k, and to the count register at wrAddr 16. A count above 8 is stored as 8. Writes to wrAddr 17..31 change nothing.
- R3: The bin index is (count * A) >> 16, where A is the state of LFSR A when the request is accepted and count is the count register at that moment. The index is therefore always below the count.
- R4: The result is lo + (((hi - lo + 1) * B) >> 16), where B is the state of LFSR B at acceptance, and lo and hi are the smaller and larger of the chosen bin's two bounds. The order in which the bounds were written does not matter.
- R5: Each LFSR is a 16-bit Fibonacci register that shifts left, with new bit 0 = s[15]^s[13]^s[12]^s[10]. LFSR A is seeded with 0xACE1 and LFSR B with 0x5EED. Both advance exactly once per accepted request, including requests made with a zero count.
- R6: A request raised while busy is low is accepted. For a nonzero count, busy goes high in the next cycle and stays high until the cycle in which the one-cycle respValid pulse appears. A request raised while busy is high is ignored and produces no response.
- R7: A bus write in the same cycle as an accepted request, or during a busy period, changes only later requests.
- R8: With a count of 0, an accepted request gives respValid with respValue 0 in the next cycle, and busy stays low.
- R9: With duplicated bin entries, such as the four-bin table in the description, each result follows R3 and R4 exactly, so the weights come only from the duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address: bin lower bounds, bin upper bounds, count |
| wrData | input | 16 | Write data |
| req | input | 1 | Request for one value |
| busy | output | 1 | A request is being solved |
| respValid | output | 1 | One-cycle pulse marking respValue |
| respValue | output | 16 | Result value |

## Verification
Two events can land in the same cycle: a register write and the acceptance of a request. The bench provokes this by raising req and wrEn on the same edge, with the write changing the bin the pending draw would use. It also writes bounds and the count while the block is busy. The scoreboard computes each expected value from the register contents as they stood before that edge, and applies the write only to the following request. Any response that uses the new contents early is reported as a miscompare.

// File: rtl/binRandPkg.sv
package binRandPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic advance;   // step both random sources
    logic snap;      // copy tables, count and random words
    logic zeroOut;   // answer 0 for an empty table
    logic loadBin;   // start the bin-index multiply
    logic loadVal;   // pick the bin bounds, start the value multiply
    logic step;      // one shift-add step
    logic finish;    // form and present the result
  } ctrlStb_t;
endpackage

// File: rtl/binRandLfsr.sv
module binRandLfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  output logic [W-1:0] state
);
  logic fbBit;
  assign fbBit = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED;
    else if (advance) state <= {state[W-2:0], fbBit};
  end

  // R5: a maximal-length register never reaches the all-zero lockup state
  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
  // R5: every advance moves to a new state
  a_r5_lfsr_moves: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> state != $past(state));
endmodule

// File: rtl/binRandCtrl.sv
module binRandCtrl
  import binRandPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic [CNT_W-1:0] countNow,
  input  logic             mulLast,
  output ctrlStb_t         stb,
  output logic             busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_LDBIN, S_MULBIN, S_LDVAL, S_MULVAL, S_FIN
  } seqState_t;

  seqState_t curState, nextState;

  always_comb begin
    stb       = '0;
    nextState = curState;
    case (curState)
      S_IDLE: begin
        if (req) begin
          stb.advance = 1'b1;
          if (countNow == '0) begin
            stb.zeroOut = 1'b1;
          end else begin
            stb.snap  = 1'b1;
            nextState = S_LDBIN;
          end
        end
      end
      S_LDBIN: begin
        stb.loadBin = 1'b1;
        nextState   = S_MULBIN;
      end
      S_MULBIN: begin
        stb.step = 1'b1;
        if (mulLast) nextState = S_LDVAL;
      end
      S_LDVAL: begin
        stb.loadVal = 1'b1;
        nextState   = S_MULVAL;
      end
      S_MULVAL: begin
        stb.step = 1'b1;
        if (mulLast) nextState = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= S_IDLE;
    else       curState <= nextState;
  end

  assign busy = (curState != S_IDLE);

  // R6: at most one datapath action per cycle
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.snap, stb.zeroOut, stb.loadBin, stb.loadVal, stb.step, stb.finish}));
  // R6: a request accepted with a nonzero count makes the block busy
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy && countNow != '0) |=> busy);
  // R8: a zero count never enters the solve sequence
  a_r8_zero_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy && countNow == '0) |=> !busy);
endmodule

// File: rtl/binRandDp.sv
module binRandDp
  import binRandPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BINS   = 8,
  localparam int IDX_W  = $clog2(BINS),
  localparam int CNT_W  = $clog2(BINS + 1),
  localparam int ADDR_W = $clog2(2 * BINS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] randA,
  input  logic [DATA_W-1:0] randB,
  output logic [CNT_W-1:0]  countNow,
  output logic              mulLast,
  output logic              respValid,
  output logic [DATA_W-1:0] respValue
);
  localparam int MUL_W = DATA_W + 1;
  localparam int ACC_W = DATA_W + MUL_W;
  localparam logic [ADDR_W-1:0] MAX_BASE = ADDR_W'(BINS);
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(2 * BINS);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(BINS);

  // live register file
  logic [DATA_W-1:0] minTab [BINS];
  logic [DATA_W-1:0] maxTab [BINS];
  logic [CNT_W-1:0]  countReg;
  // working snapshot for the request in flight
  logic [DATA_W-1:0] snapMin [BINS];
  logic [DATA_W-1:0] snapMax [BINS];
  logic [CNT_W-1:0]  cntSnap;
  logic [DATA_W-1:0] randAReg, randBReg;
  // shift-add multiplier
  logic [MUL_W-1:0]  mplier;
  logic [ACC_W-1:0]  mcand, acc;
  logic [MUL_W-1:0]  accHi;
  logic [IDX_W-1:0]  binIdx;
  logic [DATA_W-1:0] loReg, hiReg;
  logic [DATA_W-1:0] boundA, boundB, loPick, hiPick;
  logic [MUL_W-1:0]  spanPlus;

  assign countNow = countReg;
  assign accHi    = acc[ACC_W-1:DATA_W];
  assign binIdx   = accHi[IDX_W-1:0];
  assign mulLast  = (mplier[MUL_W-1:1] == '0);

  logic unusedBits;
  assign unusedBits = ^{acc[DATA_W-1:0], accHi[MUL_W-1:IDX_W]};

  // register writes; the count is clamped to the table depth
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BINS; i++) begin
        minTab[i] <= '0;
        maxTab[i] <= '0;
      end
      countReg <= '0;
    end else if (wrEn) begin
      if (wrAddr < MAX_BASE)
        minTab[wrAddr[IDX_W-1:0]] <= wrData;
      else if (wrAddr < CNT_ADDR)
        maxTab[wrAddr[IDX_W-1:0]] <= wrData;
      else if (wrAddr == CNT_ADDR)
        countReg <= (wrData > DATA_W'(BINS)) ? CNT_MAX : wrData[CNT_W-1:0];
    end
  end

  // snapshot taken when a request is accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BINS; i++) begin
        snapMin[i] <= '0;
        snapMax[i] <= '0;
      end
      cntSnap  <= '0;
      randAReg <= '0;
      randBReg <= '0;
    end else if (stb.snap) begin
      for (int i = 0; i < BINS; i++) begin
        snapMin[i] <= minTab[i];
        snapMax[i] <= maxTab[i];
      end
      cntSnap  <= countReg;
      randAReg <= randA;
      randBReg <= randB;
    end
  end

  // bound ordering for the selected bin
  always_comb begin
    boundA = snapMin[binIdx];
    boundB = snapMax[binIdx];
    if (boundA <= boundB) begin
      loPick = boundA;
      hiPick = boundB;
    end else begin
      loPick = boundB;
      hiPick = boundA;
    end
    spanPlus = {1'b0, hiPick} - {1'b0, loPick} + MUL_W'(1);
  end

  // multiplier and result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mplier    <= '0;
      mcand     <= '0;
      acc       <= '0;
      loReg     <= '0;
      hiReg     <= '0;
      respValid <= 1'b0;
      respValue <= '0;
    end else begin
      respValid <= 1'b0;
      if (stb.loadBin) begin
        mplier <= MUL_W'(cntSnap);
        mcand  <= ACC_W'(randAReg);
        acc    <= '0;
      end else if (stb.loadVal) begin
        mplier <= spanPlus;
        mcand  <= ACC_W'(randBReg);
        acc    <= '0;
        loReg  <= loPick;
        hiReg  <= hiPick;
      end else if (stb.step) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (stb.finish) begin
        respValid <= 1'b1;
        respValue <= loReg + accHi[DATA_W-1:0];
      end else if (stb.zeroOut) begin
        respValid <= 1'b1;
        respValue <= '0;
        loReg     <= '0;
        hiReg     <= '0;
      end
    end
  end

  // R3: the scaled bin index stays below the snapshot count
  a_r3_bin_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadVal |-> (accHi < MUL_W'(cntSnap)));
  // R4: every result lies inside the chosen bin bounds
  a_r4_value_in_range: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respValue >= loReg && respValue <= hiReg));
  // R2: the count never exceeds the table depth
  a_r2_count_clamped: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= CNT_MAX);
  // R8: an empty table answers zero
  a_r8_zero_value: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroOut |=> (respValid && respValue == '0));
endmodule

// File: rtl/binRandGen.sv
module binRandGen
  import binRandPkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          BINS   = 8,
  parameter logic [15:0] SEED_A = 16'hACE1,
  parameter logic [15:0] SEED_B = 16'h5EED,
  localparam int CNT_W  = $clog2(BINS + 1),
  localparam int ADDR_W = $clog2(2 * BINS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              req,
  output logic              busy,
  output logic              respValid,
  output logic [DATA_W-1:0] respValue
);
  ctrlStb_t          stb;
  logic [CNT_W-1:0]  countNow;
  logic              mulLast;
  logic [DATA_W-1:0] randA, randB;

  binRandLfsr #(.W(DATA_W), .SEED(DATA_W'(SEED_A)), .TAPS(DATA_W'(16'hB400))) uLfsrA (
    .clk(clk), .rstN(rstN), .advance(stb.advance), .state(randA));

  binRandLfsr #(.W(DATA_W), .SEED(DATA_W'(SEED_B)), .TAPS(DATA_W'(16'hB400))) uLfsrB (
    .clk(clk), .rstN(rstN), .advance(stb.advance), .state(randB));

  binRandCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .countNow(countNow),
    .mulLast(mulLast), .stb(stb), .busy(busy));

  binRandDp #(.DATA_W(DATA_W), .BINS(BINS)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .randA(randA), .randB(randB), .countNow(countNow),
    .mulLast(mulLast), .respValid(respValid), .respValue(respValue));

  // R6: the response pulse marks the end of a busy period
  a_r6_resp_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(busy)) |-> !busy);
endmodule

// File: tb/sim_binRandGen.sv
module sim_binRandGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        req = 1'b0;
  logic        busy, respValid;
  logic [15:0] respValue;

  binRandGen u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .req(req), .busy(busy), .respValid(respValid),
    .respValue(respValue));

  always #2 clk = ~clk;  // 250 MHz

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  // bench model of the register file and the random sources
  logic [15:0] mMin [8];
  logic [15:0] mMax [8];
  int          mCnt;
  logic [15:0] mA = 16'hACE1;
  logic [15:0] mB = 16'h5EED;

  logic [15:0] expQ [$];
  string       tagQ [$];

  function automatic logic [15:0] lfsrStep(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5/R3/R4 expected value for the state at acceptance
  function automatic logic [15:0] expectNext();
    longint idx, lo, hi, a, b;
    if (mCnt == 0) return 16'd0;
    idx = (longint'(mCnt) * longint'(mA)) >> 16;
    a = mMin[idx]; b = mMax[idx];
    lo = (a <= b) ? a : b;
    hi = (a <= b) ? b : a;
    return 16'(lo + (((hi - lo + 1) * longint'(mB)) >> 16));
  endfunction

  task automatic modelWrite(int addr, logic [15:0] data);
    if (addr < 8) mMin[addr] = data;
    else if (addr < 16) mMax[addr - 8] = data;
    else if (addr == 16) mCnt = (data > 16'd8) ? 8 : int'(data);
  endtask

  task automatic busWrite(int addr, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(addr, data);
  endtask

  // request driver; an optional write shares the acceptance cycle (R7)
  task automatic doRequest(string tag, bit withWr = 0, int addr = 0,
                           logic [15:0] data = '0);
    bit zeroCnt;
    @(negedge clk);
    while (busy) @(negedge clk);
    zeroCnt = (mCnt == 0);
    expQ.push_back(expectNext());
    tagQ.push_back(tag);
    mA = lfsrStep(mA);
    mB = lfsrStep(mB);
    req = 1'b1;
    if (withWr) begin wrEn = 1'b1; wrAddr = 5'(addr); wrData = data; end
    @(negedge clk);
    req = 1'b0; wrEn = 1'b0;
    if (withWr) modelWrite(addr, data);
    if (zeroCnt) begin
      check("R8 zero-count valid next cycle", respValid, 1);
      check("R8 busy stays low", busy, 0);
    end else begin
      check("R6 busy after accept", busy, 1);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && respValid && !finished) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected response", 1, 0);
      end else begin
        check(tagQ.pop_front(), respValue, expQ.pop_front());
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || busy) && guard < 200) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    check("R6 all responses returned", expQ.size(), 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mMin[i] = '0; mMax[i] = '0; end
    mCnt = 0;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 respValid after reset", respValid, 0);
    check("R1 respValue after reset", respValue, 0);
    rstN = 1'b1;

    // R8: empty table, back-to-back requests, LFSRs still advance (R5)
    doRequest("R8 zero result");
    doRequest("R8 zero result again");
    drain();

    // R2/R3/R4: single fixed bin
    busWrite(0, 16'd5); busWrite(8, 16'd5); busWrite(16, 16'd1);
    for (int i = 0; i < 3; i++) doRequest("R4 single point bin");
    drain();

    // R9: weighted example through duplicated bins
    busWrite(0, 0);  busWrite(8, 0);
    busWrite(1, 1);  busWrite(9, 10);
    busWrite(2, 11); busWrite(10, 100);
    busWrite(3, 11); busWrite(11, 100);
    busWrite(16, 4);
    for (int i = 0; i < 60; i++) doRequest("R9 weighted draw");
    drain();

    // R4: reversed bounds and full range
    busWrite(0, 16'd200); busWrite(8, 16'd100);
    busWrite(1, 16'd0);   busWrite(9, 16'hFFFF);
    busWrite(16, 2);
    for (int i = 0; i < 20; i++) doRequest("R4 reversed or full range");
    drain();

    // R2: count clamp and ignored addresses
    for (int k = 0; k < 8; k++) begin
      busWrite(k, 16'(k * 1000));
      busWrite(8 + k, 16'(k * 1000 + 37 * k + 3));
    end
    busWrite(16, 16'd12);
    busWrite(20, 16'd7);
    busWrite(31, 16'hFFFF);
    for (int i = 0; i < 30; i++) doRequest("R2 clamp to 8 bins");
    drain();

    // R7: write in the acceptance cycle and during busy
    busWrite(16, 1); busWrite(0, 16'd40); busWrite(8, 16'd50);
    doRequest("R7 write in accept cycle", 1, 0, 16'd900);
    wrEn = 1'b1; wrAddr = 5'd8; wrData = 16'd950;
    @(negedge clk); wrEn = 1'b0; modelWrite(8, 16'd950);
    wrEn = 1'b1; wrAddr = 5'd16; wrData = 16'd0;
    @(negedge clk); wrEn = 1'b0; modelWrite(16, 16'd0);
    doRequest("R7 write during busy then zero count");
    busWrite(16, 1);
    doRequest("R7 new bounds used");
    drain();

    // R6: requests while busy are ignored
    doRequest("R6 accepted request");
    req = 1'b1;
    repeat (4) @(negedge clk);
    req = 1'b0;
    drain();
    doRequest("R6 after ignored requests");
    drain();

    report();
  end
endmodule